// File: doc/BRIEF.md
# Deficit Round Robin Packet Arbiter

This block shares one output among several traffic-class queues, handing over whole packets one at a time. For every class it receives a valid flag and the length of the packet at the head of that queue. It grants a class and holds the grant until the end-of-packet handshake on `eop_i`. The long-run bandwidth each class gets equals its programmed quantum divided by the sum of all quanta.

The scheduler walks the classes in ascending order and wraps after the last one. When it reaches a class with a waiting packet, it adds that class's quantum to the class's deficit counter. It then grants packets from that class for as long as the head length does not exceed the deficit. Each finished packet subtracts its length from the deficit. An empty class is passed over without a quantum, and its deficit is held at zero. A packet longer than one quantum keeps its credit and gathers more on later rounds. A small register port, with one request and one acknowledge, lets software set and read the quanta, read the deficits and read the number of classes.

Top module: `drr_arbiter`

## Requirements
- R1: A read of register address 0x00 returns NUM_CLASSES (4 by default). A read of any address outside 0x00 and the per-class window returns zero.
- R2: The quantum of class c sits at address 0x10 + 2*c. It can be written and read back, and it resets to QUANTUM_RST (256).
- R3: The deficit of class c sits at address 0x11 + 2*c and is read-only. A write there changes neither the deficit nor any quantum.
- R4: Every register request is acknowledged on `reg_ack_o` exactly one cycle later, and the read data is valid with the acknowledge. A read made in the same cycle as a deficit update returns the value from before that update.
- R5: When the scheduler reaches a class whose valid flag is set, it adds that class's quantum to the deficit once. It grants that class while the head length is no greater than the deficit.
- R6: `grant_o` is one-hot, with bit c for class c, or zero. It stays unchanged until `eop_i` is seen, drops in the next cycle, and the granted packet's length is then subtracted from that class's deficit.
- R7: A class with no waiting packet is passed over without a quantum being added, and its deficit reads zero.
- R8: When a class's queue becomes empty, its deficit is cleared to zero.
- R9: Classes are visited in ascending index order and wrap to 0. With equal packet sizes, the grants over a round follow the ratio of the quanta.
- R10: A head packet longer than the current deficit is not granted. Its class keeps the deficit, and the deficit grows by one quantum on each later visit until the packet fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hol_valid_i | input | NUM_CLASSES | Per-class flag: head-of-line packet waiting |
| hol_len_i | input | NUM_CLASSES*LEN_W | Per-class head packet length, class c in bits [c*LEN_W +: LEN_W] |
| eop_i | input | 1 | End-of-packet handshake for the currently granted packet |
| grant_o | output | NUM_CLASSES | One-hot grant of the class whose packet is being sent |
| reg_req_i | input | 1 | Register access request, one cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid with reg_ack_o |
| reg_ack_o | output | 1 | Acknowledge, one cycle after the request |

## Verification
A deficit readback and the deficit subtraction at end of packet can fall on the same clock edge. The bench raises `eop_i` and a deficit read in the same cycle and expects the value from before the subtraction. A later read is expected to show the reduced value. The bench also parks the pointer on a granted packet of the last class, programs quanta while that grant is held, then releases it. This makes each grant order start at class 0, so the order can be compared against a hand-computed round-robin sequence.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic [1:0] {
    ST_VISIT,
    ST_CHECK,
    ST_BUSY
  } sched_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/drr_regs.sv
module drr_regs #(
  parameter int unsigned NUM_CLASSES = 4,
  parameter int unsigned Q_W         = 12,
  parameter int unsigned DEF_W       = 13,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned QUANTUM_RST = 256,
  parameter int unsigned CLS_BASE    = 16,
  localparam int unsigned PTR_W      = $clog2(NUM_CLASSES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         ack_o,
  output logic [NUM_CLASSES*Q_W-1:0]   quantum_o,
  input  logic [NUM_CLASSES*DEF_W-1:0] deficit_i
);
  localparam int unsigned WIN_END = CLS_BASE + 2 * NUM_CLASSES;

  logic [ADDR_W-1:0] rel;
  logic [PTR_W-1:0]  idx;
  logic              in_win;
  logic              is_def;
  logic [DATA_W-1:0] rdata_d;

  assign in_win = (32'(addr_i) >= CLS_BASE) && (32'(addr_i) < WIN_END);
  assign rel    = addr_i - ADDR_W'(CLS_BASE);
  assign idx    = PTR_W'(rel >> 1);
  assign is_def = rel[0];

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_q
    logic [Q_W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= Q_W'(QUANTUM_RST);
      else if (req_i && we_i && in_win && !is_def && idx == PTR_W'(c))
        q_q <= wdata_i[Q_W-1:0];
    end
    assign quantum_o[c*Q_W +: Q_W] = q_q;
  end

  always_comb begin
    rdata_d = '0;
    if (addr_i == '0) rdata_d = DATA_W'(NUM_CLASSES);
    else if (in_win) begin
      if (is_def) rdata_d = DATA_W'(deficit_i[idx*DEF_W +: DEF_W]);
      else        rdata_d = DATA_W'(quantum_o[idx*Q_W +: Q_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= req_i;
      if (req_i && !we_i) rdata_o <= rdata_d;
    end
  end

  a_r4_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  a_r4_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  a_r3_def_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_win && is_def) |=> $stable(quantum_o));
endmodule

// File: rtl/drr_sched.sv
module drr_sched
  import drr_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = 4,
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned Q_W         = 12,
  parameter int unsigned DEF_W       = 13,
  localparam int unsigned PTR_W      = $clog2(NUM_CLASSES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CLASSES-1:0]       hol_valid_i,
  input  logic [NUM_CLASSES*LEN_W-1:0] hol_len_i,
  input  logic                         eop_i,
  input  logic [NUM_CLASSES*Q_W-1:0]   quantum_i,
  output logic [NUM_CLASSES-1:0]       grant_o,
  output logic [NUM_CLASSES*DEF_W-1:0] deficit_o
);
  sched_state_e     state_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_nxt;
  logic [LEN_W-1:0] len_q;
  logic [DEF_W-1:0] def_q [NUM_CLASSES];
  logic [LEN_W-1:0] cur_len;
  logic [DEF_W-1:0] cur_q;
  logic             cur_valid;

  assign ptr_nxt   = (32'(ptr_q) == NUM_CLASSES - 1) ? '0 : ptr_q + 1'b1;
  assign cur_len   = hol_len_i[ptr_q*LEN_W +: LEN_W];
  assign cur_q     = DEF_W'(quantum_i[ptr_q*Q_W +: Q_W]);
  assign cur_valid = hol_valid_i[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_VISIT;
      ptr_q   <= '0;
      len_q   <= '0;
      for (int c = 0; c < NUM_CLASSES; c++) def_q[c] <= '0;
    end else begin
      unique case (state_q)
        ST_VISIT: begin
          if (cur_valid) begin
            def_q[ptr_q] <= def_q[ptr_q] + cur_q;
            state_q      <= ST_CHECK;
          end else begin
            def_q[ptr_q] <= '0;
            ptr_q        <= ptr_nxt;
          end
        end
        ST_CHECK: begin
          if (!cur_valid) begin
            // queue drained: forfeit leftover credit
            def_q[ptr_q] <= '0;
            ptr_q        <= ptr_nxt;
            state_q      <= ST_VISIT;
          end else if (DEF_W'(cur_len) <= def_q[ptr_q]) begin
            len_q   <= cur_len;
            state_q <= ST_BUSY;
          end else begin
            ptr_q   <= ptr_nxt;
            state_q <= ST_VISIT;
          end
        end
        ST_BUSY: begin
          if (eop_i) begin
            def_q[ptr_q] <= def_q[ptr_q] - DEF_W'(len_q);
            state_q      <= ST_CHECK;
          end
        end
        default: state_q <= ST_VISIT;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_out
    assign grant_o[c] = (state_q == ST_BUSY) && (ptr_q == PTR_W'(c));
    assign deficit_o[c*DEF_W +: DEF_W] = def_q[c];
  end

  a_r6_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r6_grant_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && !eop_i) |=> (grant_o == $past(grant_o)));
  a_r6_grant_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && eop_i) |=> (grant_o == '0));
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY) |-> (DEF_W'(len_q) <= def_q[ptr_q]));
  a_r7_skip_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VISIT && !cur_valid) |=> (def_q[$past(ptr_q)] == '0));
endmodule

// File: rtl/drr_arbiter.sv
module drr_arbiter #(
  parameter int unsigned NUM_CLASSES = 4,
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned Q_W         = 12,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned QUANTUM_RST = 256
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CLASSES-1:0]       hol_valid_i,
  input  logic [NUM_CLASSES*LEN_W-1:0] hol_len_i,
  input  logic                         eop_i,
  output logic [NUM_CLASSES-1:0]       grant_o,
  input  logic                         reg_req_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  output logic                         reg_ack_o
);
  // deficit peaks below quantum + max length
  localparam int unsigned DEF_W = drr_pkg::max_u(LEN_W, Q_W) + 1;

  logic [NUM_CLASSES*Q_W-1:0]   quantum;
  logic [NUM_CLASSES*DEF_W-1:0] deficit;

  drr_regs #(
    .NUM_CLASSES(NUM_CLASSES),
    .Q_W        (Q_W),
    .DEF_W      (DEF_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .QUANTUM_RST(QUANTUM_RST)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (reg_req_i),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .ack_o    (reg_ack_o),
    .quantum_o(quantum),
    .deficit_i(deficit)
  );

  drr_sched #(
    .NUM_CLASSES(NUM_CLASSES),
    .LEN_W      (LEN_W),
    .Q_W        (Q_W),
    .DEF_W      (DEF_W)
  ) i_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hol_valid_i(hol_valid_i),
    .hol_len_i  (hol_len_i),
    .eop_i      (eop_i),
    .quantum_i  (quantum),
    .grant_o    (grant_o),
    .deficit_o  (deficit)
  );
endmodule

// File: tb/test_drr_arbiter.sv
module test_drr_arbiter;
  localparam int NC = 4;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] hol_valid = '0;
  logic [NC*LW-1:0] hol_len = '0;
  logic          eop = 1'b0;
  logic [NC-1:0] grant;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          ack;

  int total = 0, bad = 0, cyc = 0;
  int qlen [NC][16];
  int qhead [NC];
  int qtail [NC];

  always #10 clk = ~clk;

  drr_arbiter i_drr_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .hol_valid_i(hol_valid), .hol_len_i(hol_len),
    .eop_i(eop), .grant_o(grant), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_ack_o(ack)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_hol();
    for (int c = 0; c < NC; c++) begin
      hol_valid[c] = (qhead[c] < qtail[c]);
      hol_len[c*LW +: LW] = (qhead[c] < qtail[c]) ? LW'(qlen[c][qhead[c]]) : '0;
    end
  endtask

  task automatic push(input int c, input int len);
    qlen[c][qtail[c]] = len;
    qtail[c]++;
  endtask

  task automatic reg_write(input int a, input int d);
    req = 1'b1; we = 1'b1; addr = 8'(a); wdata = 32'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk(ack == 1'b1, "R4 write ack", int'(ack), 1);
  endtask

  task automatic reg_read(input int a, input int exp, input string tag);
    req = 1'b1; we = 1'b0; addr = 8'(a);
    @(negedge clk);
    req = 1'b0;
    chk(ack == 1'b1, "R4 read ack", int'(ack), 1);
    chk(rdata == 32'(exp), tag, int'(rdata), exp);
  endtask

  task automatic wait_grant(input int c, input string tag);
    int n = 0;
    while (grant == '0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(grant == NC'(1 << c), tag, int'(grant), 1 << c);
  endtask

  // pulse eop, pop the head, optionally read a register in the same cycle
  task automatic finish_pkt(input int c, input bit rd, input int a, input int exp, input string tag);
    eop = 1'b1;
    if (rd) begin req = 1'b1; we = 1'b0; addr = 8'(a); end
    qhead[c]++;
    drive_hol();
    @(negedge clk);
    eop = 1'b0; req = 1'b0;
    chk(grant == '0, "R6 grant drops after eop", int'(grant), 0);
    if (rd) chk(rdata == 32'(exp), tag, int'(rdata), exp);
  endtask

  task automatic hold_check(input int c);
    repeat (3) @(negedge clk);
    chk(grant == NC'(1 << c), "R6 grant held until eop", int'(grant), 1 << c);
  endtask

  task automatic park_begin();
    push(3, 10);
    drive_hol();
    wait_grant(3, "R9 park on class 3");
  endtask

  task automatic park_end();
    finish_pkt(3, 1'b0, 0, 0, "");
  endtask

  task automatic t_reset_regs();
    chk(grant == '0, "R6 reset grant idle", int'(grant), 0);
    reg_read(8'h00, NC, "R1 class count");
    reg_read(8'h08, 0, "R1 unmapped low reads zero");
    reg_read(8'h18, 0, "R1 past window reads zero");
    reg_read(8'h12, 256, "R2 quantum reset value");
    reg_write(8'h14, 8'h55);
    reg_read(8'h14, 8'h55, "R2 quantum readback");
    reg_write(8'h14, 256);
    reg_write(8'h15, 77);
    reg_read(8'h15, 0, "R3 deficit write ignored");
    reg_read(8'h14, 256, "R3 quantum untouched by deficit write");
    reg_read(8'h17, 0, "R7 idle class deficit zero");
  endtask

  task automatic t_basic_order();
    park_begin();
    push(0, 200); push(0, 200); push(1, 400); push(2, 100);
    drive_hol();
    park_end();
    wait_grant(0, "R9 first grant class 0");
    reg_read(8'h11, 256, "R5 quantum added on visit");
    hold_check(0);
    finish_pkt(0, 1'b1, 8'h11, 256, "R4 read at eop returns old deficit");
    wait_grant(2, "R10 class 1 skipped, class 2 next");
    reg_read(8'h11, 56, "R6 deficit reduced by length");
    reg_read(8'h13, 256, "R10 class 1 keeps deficit");
    reg_read(8'h17, 0, "R7 empty class 3 zero");
    finish_pkt(2, 1'b0, 0, 0, "");
    wait_grant(0, "R5 class 0 second round");
    finish_pkt(0, 1'b0, 0, 0, "");
    wait_grant(1, "R10 class 1 served after two visits");
    finish_pkt(1, 1'b0, 0, 0, "");
    repeat (10) @(negedge clk);
    reg_read(8'h11, 0, "R8 class 0 drained");
    reg_read(8'h13, 0, "R8 class 1 drained");
    reg_read(8'h15, 0, "R8 class 2 drained");
  endtask

  task automatic t_weighted();
    int exp_seq [12] = '{0, 0, 0, 1, 0, 0, 0, 1, 1, 1, 1, 1};
    park_begin();
    reg_write(8'h10, 300);
    reg_write(8'h12, 100);
    for (int i = 0; i < 6; i++) begin push(0, 100); push(1, 100); end
    drive_hol();
    park_end();
    for (int k = 0; k < 12; k++) begin
      wait_grant(exp_seq[k], "R9 weighted share order");
      finish_pkt(exp_seq[k], 1'b0, 0, 0, "");
    end
  endtask

  task automatic t_long_packet();
    park_begin();
    reg_write(8'h10, 256);
    reg_write(8'h12, 256);
    reg_write(8'h14, 50);
    push(0, 100); push(2, 120);
    drive_hol();
    park_end();
    wait_grant(0, "R5 class 0 first");
    finish_pkt(0, 1'b0, 0, 0, "");
    wait_grant(2, "R10 long packet granted later");
    reg_read(8'h15, 150, "R10 deficit accumulated over three visits");
    finish_pkt(2, 1'b0, 0, 0, "");
    repeat (6) @(negedge clk);
    reg_read(8'h15, 0, "R8 leftover cleared on drain");
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin qhead[c] = 0; qtail[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_regs();
    t_basic_order();
    t_weighted();
    t_long_packet();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule